// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block is the synchronous control core of a synchronous-buck gate driver. From one pulse-width command it decides when the high-side and the low-side switch may be driven. The command arrives already sliced into low, high and mid-window levels. Before either gate is switched on, the block confirms through a sense flag that the opposite device has really turned off, then waits a programmed number of clock cycles. A mid-window command that stays there long enough parks both gates off, so one control wire can also shed a phase. A skip input gives diode emulation by keeping the low-side switch off. A disable input and a supply-good flag override everything else.

The analog parts are reduced to input flags. Each comparator result, the skip input, the disable input and the supply flag is treated as asynchronous and passes through a two-flop synchronizer. Every delay is a parameter counted in clock cycles: the turn-on dead delay, the turn-off dead delay, the backup timeout and the tri-state hold-off. A disable line left floating is expected to read as low, because an external pull-down holds it there.

Top module: `hbg_gate_seq`

## Requirements
- R1: While the synchronized `dis_n` or `supply_ok` is low, both `hs_en` and `ls_en` are low from the next clock edge on, whatever the command.
- R2: The command `pwm_code` uses 00 for low and 10 for high. With the block enabled and `skip_n` high, a high command ends with only `hs_en` set and a low command ends with only `ls_en` set. An input change reaches the state register on the third rising edge after it is driven.
- R3: While the synchronized `skip_n` is low, `ls_en` is low from the next clock edge on. A high command still turns `hs_en` on, and a low command leaves both outputs low.
- R4: The code 01 means tri-state. If it is held without a break, both outputs drop on the (HOLDOFF_CYC+3)-th edge after it is driven. If it is held for only HOLDOFF_CYC-1 cycles, the earlier output state is kept.
- R5: After a park, a low command turns `ls_en` on and a high command turns `hs_en` on.
- R6: When the command goes from low to high, `ls_en` drops first. `hs_en` rises only once `ls_gate_low` has been seen for DEAD_ON_CYC+1 cycles in a row. If `ls_gate_low` is already set, `hs_en` rises on edge 4+DEAD_ON_CYC.
- R7: When the command goes from high to low, `hs_en` drops first. `ls_en` rises once `sw_node_low` has been seen for DEAD_OFF_CYC+1 cycles in a row, which with the flag already set is edge 4+DEAD_OFF_CYC. While neither `sw_node_low` nor `hs_gate_low` is set, `ls_en` stays low.
- R8: Once `hs_gate_low` is seen during the wait for the high side to turn off, `ls_en` rises TIMEOUT_CYC+1 cycles later even if `sw_node_low` never comes. With `hs_gate_low` driven together with the low command, this is edge TIMEOUT_CYC+4.
- R9: `hs_en` and `ls_en` are never high in the same cycle.
- R10: A command reversal during either dead-time wait abandons that wait and heads for the new target.
- R11: The code 11 is handled exactly like 01.
- R12: During reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_code | input | 2 | Sliced command: 00 low, 10 high, 01/11 mid-window |
| skip_n | input | 1 | Active-low skip (diode emulation) request |
| dis_n | input | 1 | Active-low output disable |
| supply_ok | input | 1 | Driver supply above lockout threshold |
| ls_gate_low | input | 1 | Low-side gate sensed below its off threshold |
| sw_node_low | input | 1 | Switch node sensed below its threshold |
| hs_gate_low | input | 1 | High-side gate-source sensed below its threshold |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
Two mechanisms can release the low side in the same wait: the switch-node dead delay and the backup timeout. The turn-off latency test raises `sw_node_low` and `hs_gate_low` in the same cycle, so both counters run together. The result is judged by the exact edge on which `ls_en` rises, which must be the dead-delay edge and not the timeout edge. The bench also reverses the command while a wait is stalled on a missing sense flag. It checks that the new target wins, and a monitor sampling every cycle confirms that the two outputs are never high together.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_LS_ON,
    ST_WAIT_LS_OFF,
    ST_HS_ON,
    ST_WAIT_HS_OFF,
    ST_TRI_PARK
  } hbg_state_e;

  typedef enum logic [1:0] {
    W_OFF,
    W_LO,
    W_HI
  } hbg_want_e;

  localparam logic [1:0] PWM_LO = 2'b00;
  localparam logic [1:0] PWM_HI = 2'b10;

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/hbg_pwm_level.sv
module hbg_pwm_level
  import hbg_pkg::*;
#(
  parameter int HOLDOFF_CYC = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  output hbg_want_e  want,
  output logic       parked
);

  localparam int CW = $clog2(HOLDOFF_CYC + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLDOFF_CYC);

  logic [CW-1:0] tri_cnt_q, tri_cnt_d;
  hbg_want_e     last_q;
  logic          is_hi, is_lo, is_tri, cnt_en;

  always_comb begin
    is_hi  = (code == PWM_HI);
    is_lo  = (code == PWM_LO);
    is_tri = code[0];
    parked = is_tri && (tri_cnt_q == HOLD_C);
    if (is_hi)       want = W_HI;
    else if (is_lo)  want = W_LO;
    else if (parked) want = W_OFF;
    else             want = last_q;
    cnt_en    = !(is_tri && (tri_cnt_q == HOLD_C));
    tri_cnt_d = is_tri ? (tri_cnt_q + CW'(1)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tri_cnt_q <= '0;
      last_q    <= W_OFF;
    end else begin
      if (cnt_en) tri_cnt_q <= tri_cnt_d;
      last_q <= want;
    end
  end

endmodule

// File: rtl/hbg_seq_fsm.sv
module hbg_seq_fsm
  import hbg_pkg::*;
#(
  parameter int DEAD_ON_CYC  = 1,
  parameter int DEAD_OFF_CYC = 2,
  parameter int TIMEOUT_CYC  = 25
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      skip_n,
  input  hbg_want_e want,
  input  logic      ls_low,
  input  logic      sw_low,
  input  logic      hs_low,
  output logic      hs_en,
  output logic      ls_en
);

  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] DON_C  = CW'(DEAD_ON_CYC);
  localparam logic [CW-1:0] DOFF_C = CW'(DEAD_OFF_CYC);
  localparam logic [CW-1:0] TMO_C  = CW'(TIMEOUT_CYC);

  if (TIMEOUT_CYC <= DEAD_OFF_CYC || TIMEOUT_CYC <= DEAD_ON_CYC) begin : g_bad_timeout
    $error("backup timeout must exceed both dead delays");
  end

  hbg_state_e    state_q, state_d;
  logic [CW-1:0] dead_q, dead_d, tmo_q, tmo_d, dead_lim;
  logic          stay, dead_flag;

  always_comb begin
    state_d = state_q;
    if (!enable) begin
      state_d = ST_OFF;
    end else if (want == W_HI) begin
      case (state_q)
        ST_HS_ON:       state_d = ST_HS_ON;
        ST_WAIT_LS_OFF: if (ls_low && dead_q == DON_C) state_d = ST_HS_ON;
        default:        state_d = ST_WAIT_LS_OFF;
      endcase
    end else if (want == W_LO && skip_n) begin
      case (state_q)
        ST_LS_ON:       state_d = ST_LS_ON;
        ST_WAIT_HS_OFF: if ((sw_low && dead_q == DOFF_C) || tmo_q == TMO_C)
                          state_d = ST_LS_ON;
        default:        state_d = ST_WAIT_HS_OFF;
      endcase
    end else begin
      state_d = (want == W_OFF) ? ST_TRI_PARK : ST_OFF;
    end
  end

  always_comb begin
    stay      = (state_d == state_q);
    dead_flag = (state_q == ST_WAIT_LS_OFF) ? ls_low : sw_low;
    dead_lim  = (state_q == ST_WAIT_LS_OFF) ? DON_C : DOFF_C;
    dead_d    = '0;
    tmo_d     = '0;
    if (stay) begin
      if ((state_q == ST_WAIT_LS_OFF || state_q == ST_WAIT_HS_OFF) && dead_flag)
        dead_d = (dead_q < dead_lim) ? dead_q + CW'(1) : dead_q;
      if (state_q == ST_WAIT_HS_OFF && (hs_low || tmo_q != '0) && tmo_q != TMO_C)
        tmo_d = tmo_q + CW'(1);
      else
        tmo_d = tmo_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      dead_q  <= '0;
      tmo_q   <= '0;
    end else begin
      state_q <= state_d;
      dead_q  <= dead_d;
      tmo_q   <= tmo_d;
    end
  end

  assign hs_en = (state_q == ST_HS_ON);
  assign ls_en = (state_q == ST_LS_ON);

endmodule

// File: rtl/hbg_gate_seq.sv
module hbg_gate_seq
  import hbg_pkg::*;
#(
  parameter int HOLDOFF_CYC  = 20,
  parameter int DEAD_ON_CYC  = 1,
  parameter int DEAD_OFF_CYC = 2,
  parameter int TIMEOUT_CYC  = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_code,
  input  logic       skip_n,
  input  logic       dis_n,
  input  logic       supply_ok,
  input  logic       ls_gate_low,
  input  logic       sw_node_low,
  input  logic       hs_gate_low,
  output logic       hs_en,
  output logic       ls_en
);

  localparam int SW = 8;

  logic [SW-1:0] raw_in, syn_in;
  logic [1:0]    code_s;
  logic          skip_s, dis_s, ok_s, ls_low_s, sw_low_s, hs_low_s, en_s, parked;
  hbg_want_e     want;

  assign raw_in = {pwm_code, skip_n, dis_n, supply_ok, ls_gate_low, sw_node_low, hs_gate_low};

  hbg_sync #(.WIDTH(SW)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign {code_s, skip_s, dis_s, ok_s, ls_low_s, sw_low_s, hs_low_s} = syn_in;
  assign en_s = dis_s && ok_s;

  hbg_pwm_level #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_level (
    .clk(clk), .rst_n(rst_n), .code(code_s), .want(want), .parked(parked)
  );

  hbg_seq_fsm #(
    .DEAD_ON_CYC(DEAD_ON_CYC), .DEAD_OFF_CYC(DEAD_OFF_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(en_s), .skip_n(skip_s), .want(want),
    .ls_low(ls_low_s), .sw_low(sw_low_s), .hs_low(hs_low_s),
    .hs_en(hs_en), .ls_en(ls_en)
  );

endmodule

// File: rtl/hbg_gate_seq_chk.sv
module hbg_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_en,
  input logic ls_en,
  input logic en_s,
  input logic skip_s,
  input logic ls_low_s,
  input logic parked
);

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  p_disable_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (!hs_en && !ls_en));

  p_skip_no_ls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_s |=> !ls_en);

  p_park_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    parked |=> (!hs_en && !ls_en));

  p_hs_after_ls_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(ls_low_s) && !$past(ls_en)));

  p_ls_after_hs_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> !$past(hs_en));

endmodule

bind hbg_gate_seq hbg_gate_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .ls_en(ls_en), .en_s(en_s),
  .skip_s(skip_s), .ls_low_s(ls_low_s), .parked(parked)
);

// File: tb/hbg_gate_seq_tb_top.sv
module hbg_gate_seq_tb_top;

  localparam int HOLD = 20;
  localparam int DON  = 1;
  localparam int DOFF = 2;
  localparam int TMO  = 25;

  logic clk, rst_n;
  logic [1:0] pwm_code;
  logic skip_n, dis_n, supply_ok, ls_gate_low, sw_node_low, hs_gate_low;
  logic hs_en, ls_en;
  int tests, fails, overlaps;
  bit done;

  hbg_gate_seq #(.HOLDOFF_CYC(HOLD), .DEAD_ON_CYC(DON), .DEAD_OFF_CYC(DOFF),
                 .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_code(pwm_code), .skip_n(skip_n), .dis_n(dis_n),
    .supply_ok(supply_ok), .ls_gate_low(ls_gate_low), .sw_node_low(sw_node_low),
    .hs_gate_low(hs_gate_low), .hs_en(hs_en), .ls_en(ls_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0] code;
    logic       skn, dsn, ok, lsl, swl, hsl;
    logic [7:0] wt;
    logic       ehs, els;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,8'd10,1'b0,1'b1,4'd2},  // R2 low
    '{2'b10,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,8'd10,1'b1,1'b0,4'd2},  // R2 high
    '{2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,8'd10,1'b0,1'b1,4'd2},  // R2 low again
    '{2'b10,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,8'd10,1'b0,1'b0,4'd6},  // R6 stalled
    '{2'b00,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,8'd10,1'b0,1'b1,4'd10}, // R10 retarget
    '{2'b00,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,8'd10,1'b0,1'b0,4'd3},  // R3 skip low
    '{2'b10,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,8'd10,1'b1,1'b0,4'd3},  // R3 skip high
    '{2'b00,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,8'd10,1'b0,1'b0,4'd3},  // R3 skip low
    '{2'b00,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,8'd10,1'b0,1'b0,4'd1},  // R1 disabled
    '{2'b10,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,8'd10,1'b0,1'b0,4'd1},  // R1 no supply
    '{2'b10,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,8'd10,1'b1,1'b0,4'd2},  // R2 recover
    '{2'b11,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,8'd10,1'b1,1'b0,4'd11}, // R11 short
    '{2'b11,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,8'd30,1'b0,1'b0,4'd11}, // R11 parks
    '{2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,8'd10,1'b0,1'b1,4'd5},  // R5 exit low
    '{2'b10,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,8'd10,1'b1,1'b0,4'd2},  // R2
    '{2'b00,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,8'd10,1'b0,1'b0,4'd7},  // R7 no sense
    '{2'b00,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,8'd40,1'b0,1'b1,4'd8},  // R8 timeout
    '{2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,8'd40,1'b0,1'b0,4'd4},  // R4 park
    '{2'b10,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,8'd10,1'b1,1'b0,4'd5}   // R5 exit high
  };

  task automatic apply(input logic [1:0] c, input logic sk, input logic ds,
                       input logic ok, input logic ll, input logic sl, input logic hl);
    pwm_code = c; skip_n = sk; dis_n = ds; supply_ok = ok;
    ls_gate_low = ll; sw_node_low = sl; hs_gate_low = hl;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {hs,ls} actual %b expected %b", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && hs_en && ls_en) overlaps++;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; overlaps = 0; done = 1'b0;
    rst_n = 1'b0;
    apply(2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    wait_n(4);
    chk("R12 reset state", {hs_en, ls_en}, 2'b00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].code, VEC[i].skn, VEC[i].dsn, VEC[i].ok, VEC[i].lsl, VEC[i].swl, VEC[i].hsl);
      wait_n(int'(VEC[i].wt));
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), {hs_en, ls_en}, {VEC[i].ehs, VEC[i].els});
    end

    // R6: exact turn-on latency with low-side already sensed off
    apply(2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1); wait_n(10);
    apply(2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    wait_n(3);       chk("R6 low side released first", {hs_en, ls_en}, 2'b00);
    wait_n(DON);     chk("R6 high side not yet on", {hs_en, ls_en}, 2'b00);
    wait_n(1);       chk("R6 high side on after dead delay", {hs_en, ls_en}, 2'b10);

    // R7: exact turn-off latency, timeout also running (dead path must win)
    apply(2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    wait_n(3);       chk("R7 high side released first", {hs_en, ls_en}, 2'b00);
    wait_n(DOFF);    chk("R7 low side not yet on", {hs_en, ls_en}, 2'b00);
    wait_n(1);       chk("R7 low side on after dead delay", {hs_en, ls_en}, 2'b01);

    // R8: backup timeout with switch node never sensed low
    apply(2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); wait_n(10);
    apply(2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    wait_n(TMO + 3); chk("R8 low side before timeout", {hs_en, ls_en}, 2'b00);
    wait_n(1);       chk("R8 low side at timeout", {hs_en, ls_en}, 2'b01);

    // R4: full hold-off parks on the exact edge
    apply(2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1); wait_n(10);
    apply(2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    wait_n(HOLD + 2); chk("R4 still on before hold-off", {hs_en, ls_en}, 2'b01);
    wait_n(1);        chk("R4 parked after hold-off", {hs_en, ls_en}, 2'b00);

    // R4: tri-state one cycle short of the hold-off leaves the low side on
    apply(2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1); wait_n(10);
    apply(2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    begin
      logic dropped;
      dropped = 1'b0;
      for (int i = 1; i <= HOLD + 8; i++) begin
        @(negedge clk);
        if (!ls_en || hs_en) dropped = 1'b1;
        if (i == HOLD - 1) pwm_code = 2'b00;
      end
      chk("R4 short tri-state kept low side", {1'b0, dropped}, 2'b00);
    end

    chk($sformatf("R9 overlap cycles %0d", overlaps), {1'b0, overlaps != 0}, 2'b00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule